// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches five modem status lines and keeps two sticky change flags: ring indicator, clear-to-send, carrier detect, data-set-ready, and the secondary receive line. The secondary receive line is not a pin. It is the secondary transmit control bit fed back into the block. Every line, the loopback included, passes through a multi-stage synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. Rising and falling edges both count, and no debounce is applied, so a single edge is enough to set a flag.

Change flag A always follows ring and clear-to-send. It also follows the three secondary lines (carrier detect, data-set-ready, secondary receive) when static option A is selected. Change flag B follows those same three secondary lines only when static option B is selected. Each flag is held by a two-state machine:

- CHG_QUIET moves to CHG_LATCHED on a watched edge (the set transition).
- CHG_LATCHED returns to CHG_QUIET on a status read with no edge in the same cycle (the read-clear transition).
- Either state goes to CHG_QUIET on controller clear or bus clear (the hard-clear transition).
- Otherwise the state holds.

An interrupt request is raised while flag A is set and the change interrupt enable is 1. The block also presents a 16-bit status word for the host's register read path.

The edge detector stays disarmed until the synchronizer pipeline has filled after reset. This keeps lines that are already high at reset from reporting a change.

Top module: `modem_chg_det`

## Requirements
- R1: After reset, both flags, the interrupt request, every live line output and the status word are 0.
- R2: Flag A sets on a single rising or falling edge of ring or clear-to-send, and it stays set until it is cleared.
- R3: With option A at 1, an edge on carrier detect, data-set-ready or secondary receive sets flag A. With option A at 0, such edges leave flag A at 0.
- R4: With option B at 1, an edge on carrier detect, data-set-ready or secondary receive sets flag B. Ring and clear-to-send never set flag B. With option B at 0, flag B stays 0.
- R5: A one-cycle status read strobe clears both flags when no watched edge falls in the same cycle.
- R6: Controller clear or bus clear clears both flags, even when a watched edge falls in the same cycle.
- R7: When a watched edge and a status read fall in the same cycle, the flag ends up set.
- R8: The interrupt request equals flag A AND the change interrupt enable. Flag B never raises it.
- R9: The live secondary receive output follows the secondary transmit bit, and a change of that bit counts as a secondary receive edge.
- R10: The status word carries flag A in bit 15, ring in 14, clear-to-send in 13, carrier detect in 12, secondary receive in 10, data-set-ready in 9 and flag B in bit 0. All other bits read 0.
- R11: A line change reaches its live output SYNC_STAGES clock edges after the input changes. It reaches the flag one edge later.
- R12: A line held high through reset shows as high on its live output but does not set a flag. Later edges on that line are detected normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_i | input | 1 | Ring indicator line |
| cts_i | input | 1 | Clear-to-send line |
| dcd_i | input | 1 | Carrier detect line |
| dsr_i | input | 1 | Data-set-ready line |
| sec_tx_i | input | 1 | Secondary transmit control bit, looped back as secondary receive |
| opt_a_i | input | 1 | Static option: secondary lines also feed flag A |
| opt_b_i | input | 1 | Static option: secondary lines feed flag B |
| stat_rd_i | input | 1 | Status register read strobe; clears both flags |
| ctl_clr_i | input | 1 | Controller clear |
| bus_clr_i | input | 1 | Bus clear |
| chg_ie_i | input | 1 | Change interrupt enable |
| ring_o | output | 1 | Synchronized ring level |
| cts_o | output | 1 | Synchronized clear-to-send level |
| dcd_o | output | 1 | Synchronized carrier detect level |
| dsr_o | output | 1 | Synchronized data-set-ready level |
| secrx_o | output | 1 | Synchronized secondary receive level |
| flag_a_o | output | 1 | Change flag A |
| flag_b_o | output | 1 | Change flag B |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 16 | Status word |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This places the live-output and flag latency checks at three and four clock edges, so they can only match if the parameter actually sets the synchronizer depth and the arming window. With the deeper pipeline, the bench can also put a status read or a clear into the exact cycle in which a pending edge reaches the flag machine. That lets it test the set-over-read and clear-over-set priorities directly. A reset with ring and clear-to-send held high confirms that the arming window suppresses the apparent edge seen while the pipeline fills.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int LINE_N = 5;

    // Line index within the synchronized line vector
    localparam int L_RING = 0;
    localparam int L_CTS  = 1;
    localparam int L_DCD  = 2;
    localparam int L_DSR  = 3;
    localparam int L_SEC  = 4;

    // Status word layout (decoded by the host read path)
    localparam int STAT_W = 16;
    localparam int B_FLGA = 15;
    localparam int B_RING = 14;
    localparam int B_CTS  = 13;
    localparam int B_DCD  = 12;
    localparam int B_SEC  = 10;
    localparam int B_DSR  = 9;
    localparam int B_FLGB = 0;

    localparam int FLAG_N = 2;

    typedef enum logic {
        CHG_QUIET   = 1'b0,
        CHG_LATCHED = 1'b1
    } chg_state_e;

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/msd_edge.sv
module msd_edge #(
    parameter int W       = 5,
    parameter int ARM_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] toggles
);

    localparam int CW = $clog2(ARM_CYC + 1);
    localparam logic [CW-1:0] ARM_LAST = CW'(ARM_CYC);

    logic [W-1:0]  prev_q;
    logic [CW-1:0] arm_cnt_q;
    logic          armed;

    assign armed = (arm_cnt_q == ARM_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            arm_cnt_q <= '0;
        end else begin
            prev_q <= lvl;
            if (!armed) begin
                arm_cnt_q <= arm_cnt_q + CW'(1);
            end
        end
    end

    assign toggles = armed ? (lvl ^ prev_q) : '0;

endmodule

// File: rtl/msd_flag_fsm.sv
module msd_flag_fsm
    import msd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_clr,
    input  logic hard_clr,
    output logic flag
);

    chg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHG_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHG_QUIET: begin
                if (hit && !hard_clr) begin
                    state_d = CHG_LATCHED;
                end
            end
            CHG_LATCHED: begin
                if (hard_clr) begin
                    state_d = CHG_QUIET;
                end else if (rd_clr && !hit) begin
                    state_d = CHG_QUIET;
                end
            end
            default: state_d = CHG_QUIET;
        endcase
    end

    always_comb begin
        flag = (state_q == CHG_LATCHED);
    end

endmodule

// File: rtl/modem_chg_det.sv
module modem_chg_det
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_i,
    input  logic              cts_i,
    input  logic              dcd_i,
    input  logic              dsr_i,
    input  logic              sec_tx_i,
    input  logic              opt_a_i,
    input  logic              opt_b_i,
    input  logic              stat_rd_i,
    input  logic              ctl_clr_i,
    input  logic              bus_clr_i,
    input  logic              chg_ie_i,
    output logic              ring_o,
    output logic              cts_o,
    output logic              dcd_o,
    output logic              dsr_o,
    output logic              secrx_o,
    output logic              flag_a_o,
    output logic              flag_b_o,
    output logic              irq_o,
    output logic [STAT_W-1:0] stat_o
);

    localparam int ARM_CYC = SYNC_STAGES + 1;

    logic [LINE_N-1:0] raw_lines;
    logic [LINE_N-1:0] live;
    logic [LINE_N-1:0] tog;
    logic              prim_edge;
    logic              aux_edge;
    logic [FLAG_N-1:0] flag_hit;
    logic [FLAG_N-1:0] flag_q;
    logic              hard_clr;

    always_comb begin
        raw_lines         = '0;
        raw_lines[L_RING] = ring_i;
        raw_lines[L_CTS]  = cts_i;
        raw_lines[L_DCD]  = dcd_i;
        raw_lines[L_DSR]  = dsr_i;
        raw_lines[L_SEC]  = sec_tx_i;   // loopback of the secondary transmit bit
    end

    msd_sync #(
        .W      (LINE_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (live)
    );

    msd_edge #(
        .W       (LINE_N),
        .ARM_CYC (ARM_CYC)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (live),
        .toggles(tog)
    );

    assign prim_edge = tog[L_RING] | tog[L_CTS];
    assign aux_edge  = tog[L_DCD] | tog[L_DSR] | tog[L_SEC];
    assign hard_clr  = ctl_clr_i | bus_clr_i;

    assign flag_hit[0] = prim_edge | (opt_a_i & aux_edge);
    assign flag_hit[1] = opt_b_i & aux_edge;

    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        msd_flag_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (flag_hit[f]),
            .rd_clr  (stat_rd_i),
            .hard_clr(hard_clr),
            .flag    (flag_q[f])
        );
    end

    assign flag_a_o = flag_q[0];
    assign flag_b_o = flag_q[1];
    assign irq_o    = flag_q[0] & chg_ie_i;

    assign ring_o  = live[L_RING];
    assign cts_o   = live[L_CTS];
    assign dcd_o   = live[L_DCD];
    assign dsr_o   = live[L_DSR];
    assign secrx_o = live[L_SEC];

    always_comb begin
        stat_o         = '0;
        stat_o[B_FLGA] = flag_q[0];
        stat_o[B_RING] = live[L_RING];
        stat_o[B_CTS]  = live[L_CTS];
        stat_o[B_DCD]  = live[L_DCD];
        stat_o[B_SEC]  = live[L_SEC];
        stat_o[B_DSR]  = live[L_DSR];
        stat_o[B_FLGB] = flag_q[1];
    end

endmodule

// File: rtl/modem_chg_det_chk.sv
module modem_chg_det_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       opt_b_i,
    input logic       stat_rd_i,
    input logic       ctl_clr_i,
    input logic       bus_clr_i,
    input logic       flag_a_o,
    input logic       flag_b_o,
    input logic       irq_o,
    input logic [1:0] hit
);

    // R6
    hard_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clr_i || bus_clr_i) |=> (!flag_a_o && !flag_b_o));

    // R5
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !hit[0] && !ctl_clr_i && !bus_clr_i) |=> !flag_a_o);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && !ctl_clr_i && !bus_clr_i) |=> flag_a_o);

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a_o && !stat_rd_i && !ctl_clr_i && !bus_clr_i) |=> flag_a_o);

    // R4
    opt_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!opt_b_i && !flag_b_o) |=> !flag_b_o);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_b_o && !flag_a_o) |-> !irq_o);

endmodule

bind modem_chg_det modem_chg_det_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opt_b_i  (opt_b_i),
    .stat_rd_i(stat_rd_i),
    .ctl_clr_i(ctl_clr_i),
    .bus_clr_i(bus_clr_i),
    .flag_a_o (flag_a_o),
    .flag_b_o (flag_b_o),
    .irq_o    (irq_o),
    .hit      (flag_hit)
);

// File: tb/tb_modem_chg_det.sv
module tb_modem_chg_det;

    localparam int SYNC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ring_i = 0, cts_i = 0, dcd_i = 0, dsr_i = 0, sec_tx_i = 0;
    logic        opt_a_i = 0, opt_b_i = 0;
    logic        stat_rd_i = 0, ctl_clr_i = 0, bus_clr_i = 0, chg_ie_i = 0;
    logic        ring_o, cts_o, dcd_o, dsr_o, secrx_o;
    logic        flag_a_o, flag_b_o, irq_o;
    logic [15:0] stat_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    modem_chg_det #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n),
        .ring_i(ring_i), .cts_i(cts_i), .dcd_i(dcd_i), .dsr_i(dsr_i),
        .sec_tx_i(sec_tx_i), .opt_a_i(opt_a_i), .opt_b_i(opt_b_i),
        .stat_rd_i(stat_rd_i), .ctl_clr_i(ctl_clr_i), .bus_clr_i(bus_clr_i),
        .chg_ie_i(chg_ie_i),
        .ring_o(ring_o), .cts_o(cts_o), .dcd_o(dcd_o), .dsr_o(dsr_o),
        .secrx_o(secrx_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o),
        .irq_o(irq_o), .stat_o(stat_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(SYNC + 2);
    endtask

    task automatic rd_pulse();
        stat_rd_i = 1'b1;
        tick(1);
        stat_rd_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "flag_a", 16'(flag_a_o), 16'h0);
        chk("R1", "flag_b", 16'(flag_b_o), 16'h0);
        chk("R1", "irq", 16'(irq_o), 16'h0);
        chk("R1", "stat", stat_o, 16'h0000);
    endtask

    task automatic t_ring_cts();
        opt_a_i = 1'b0; opt_b_i = 1'b1;
        ring_i = 1'b1;
        tick(SYNC - 1);
        chk("R11", "ring live early", 16'(ring_o), 16'h0);
        tick(1);
        chk("R11", "ring live on time", 16'(ring_o), 16'h1);
        chk("R11", "flag_a not yet", 16'(flag_a_o), 16'h0);
        tick(1);
        chk("R2", "flag_a rising ring", 16'(flag_a_o), 16'h1);
        chk("R10", "stat ring+A", stat_o, 16'hC000);
        tick(3);
        chk("R2", "flag_a sticky", 16'(flag_a_o), 16'h1);
        rd_pulse();
        chk("R5", "flag_a after read", 16'(flag_a_o), 16'h0);
        ring_i = 1'b0;
        tick(SYNC + 1);
        chk("R2", "flag_a falling ring", 16'(flag_a_o), 16'h1);
        rd_pulse();
        cts_i = 1'b1;
        tick(SYNC + 1);
        chk("R2", "flag_a cts", 16'(flag_a_o), 16'h1);
        chk("R4", "flag_b untouched by cts", 16'(flag_b_o), 16'h0);
        chk("R10", "stat cts+A", stat_o, 16'hA000);
        cts_i = 1'b0;
        tick(SYNC + 1);
        rd_pulse();
        opt_b_i = 1'b0;
    endtask

    task automatic t_opt_a();
        opt_a_i = 1'b0; opt_b_i = 1'b0;
        dcd_i = 1'b1;
        tick(SYNC + 3);
        chk("R3", "dcd ignored, option A off", 16'(flag_a_o), 16'h0);
        chk("R4", "dcd ignored, option B off", 16'(flag_b_o), 16'h0);
        chk("R10", "stat dcd only", stat_o, 16'h1000);
        opt_a_i = 1'b1;
        dsr_i = 1'b1;
        tick(SYNC + 1);
        chk("R3", "dsr sets A", 16'(flag_a_o), 16'h1);
        chk("R4", "B off", 16'(flag_b_o), 16'h0);
        rd_pulse();
        sec_tx_i = 1'b1;
        tick(SYNC + 1);
        chk("R9", "secrx loopback", 16'(secrx_o), 16'h1);
        chk("R9", "secrx edge sets A", 16'(flag_a_o), 16'h1);
        chk("R10", "stat A,dcd,sec,dsr", stat_o, 16'h9600);
        rd_pulse();
        opt_a_i = 1'b0;
        dcd_i = 1'b0; dsr_i = 1'b0; sec_tx_i = 1'b0;
        tick(SYNC + 3);
        chk("R3", "falls ignored, option A off", 16'(flag_a_o), 16'h0);
    endtask

    task automatic t_opt_b();
        opt_b_i = 1'b1;
        dcd_i = 1'b1;
        tick(SYNC + 1);
        chk("R4", "dcd sets B", 16'(flag_b_o), 16'h1);
        chk("R3", "A stays clear", 16'(flag_a_o), 16'h0);
        chk("R10", "stat dcd+B", stat_o, 16'h1001);
        rd_pulse();
        chk("R5", "B cleared by read", 16'(flag_b_o), 16'h0);
        sec_tx_i = 1'b1;
        tick(SYNC + 1);
        chk("R9", "secrx edge sets B", 16'(flag_b_o), 16'h1);
        rd_pulse();
        opt_a_i = 1'b1;
        dsr_i = 1'b1;
        tick(SYNC + 1);
        chk("R3", "dsr sets A with both options", 16'(flag_a_o), 16'h1);
        chk("R4", "dsr sets B with both options", 16'(flag_b_o), 16'h1);
        ctl_clr_i = 1'b1;
        tick(1);
        ctl_clr_i = 1'b0;
        chk("R6", "controller clear flags", {flag_a_o, flag_b_o}, 16'h0);
        dsr_i = 1'b0;
        tick(SYNC + 1);
        chk("R4", "dsr fall sets B", 16'(flag_b_o), 16'h1);
        bus_clr_i = 1'b1;
        tick(1);
        bus_clr_i = 1'b0;
        chk("R6", "bus clear flags", {flag_a_o, flag_b_o}, 16'h0);
        opt_a_i = 1'b0; opt_b_i = 1'b0;
        dcd_i = 1'b0; sec_tx_i = 1'b0;
        tick(SYNC + 3);
    endtask

    task automatic t_priority();
        ring_i = 1'b1;
        tick(SYNC + 1);
        chk("R2", "flag_a preset", 16'(flag_a_o), 16'h1);
        ring_i = 1'b0;
        tick(SYNC);
        stat_rd_i = 1'b1;
        tick(1);
        stat_rd_i = 1'b0;
        chk("R7", "set beats read", 16'(flag_a_o), 16'h1);
        rd_pulse();
        chk("R5", "plain read clears", 16'(flag_a_o), 16'h0);
        ring_i = 1'b1;
        tick(SYNC);
        ctl_clr_i = 1'b1;
        tick(1);
        ctl_clr_i = 1'b0;
        chk("R6", "clear beats set", 16'(flag_a_o), 16'h0);
        tick(2);
        chk("R6", "edge not replayed", 16'(flag_a_o), 16'h0);
        ring_i = 1'b0;
        tick(SYNC + 1);
        rd_pulse();
    endtask

    task automatic t_irq();
        chg_ie_i = 1'b0;
        ring_i = 1'b1;
        tick(SYNC + 1);
        chk("R8", "irq masked", 16'(irq_o), 16'h0);
        chg_ie_i = 1'b1;
        #2;
        chk("R8", "irq enabled", 16'(irq_o), 16'h1);
        tick(0);
        rd_pulse();
        chk("R8", "irq after read", 16'(irq_o), 16'h0);
        opt_b_i = 1'b1;
        dcd_i = 1'b1;
        tick(SYNC + 1);
        chk("R8", "flag_b set", 16'(flag_b_o), 16'h1);
        chk("R8", "flag_b no irq", 16'(irq_o), 16'h0);
        rd_pulse();
        opt_b_i = 1'b0; chg_ie_i = 1'b0;
        ring_i = 1'b0; dcd_i = 1'b0;
        tick(SYNC + 3);
        rd_pulse();
    endtask

    task automatic t_reset_high();
        ring_i = 1'b1; cts_i = 1'b1;
        do_reset();
        tick(3);
        chk("R12", "no flag from held lines", 16'(flag_a_o), 16'h0);
        chk("R12", "stat live lines", stat_o, 16'h6000);
        ring_i = 1'b0;
        tick(SYNC + 1);
        chk("R12", "later edge detected", 16'(flag_a_o), 16'h1);
        rd_pulse();
        cts_i = 1'b0;
        tick(SYNC + 3);
        rd_pulse();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ring_cts();
        t_opt_a();
        t_opt_b();
        t_priority();
        t_irq();
        t_reset_high();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule